// File: doc/BRIEF.md
# Double-Buffered Converter Command Register Bank

This block sits behind a two-wire serial slave and turns the bytes that slave receives into register updates for a 12-bit voltage converter. The slave hands over each received byte as a strobe, marked as either the first or a later byte of a write. It then sends a commit strobe at the falling clock edge of that byte's acknowledge bit, or an abort flag when the transfer ends early. The block keeps two 12-bit data registers: a staging register and the register that drives the converter. It also keeps a 2-bit output-mode register. The block drives the converter code, the output buffer enable and the termination select.

The first byte of a write carries a 4-bit command in its upper nibble and the top four data bits in its lower nibble. Data commands need a second byte, which carries the low eight data bits. Power-mode, promote and read commands complete at the acknowledge of the first byte. The block also forms a 16-bit readback word for the slave to shift out, and pulses a flag when a read request is accepted.

Top module: `dac_cmd_bank`

## Requirements
- R1: After reset the staging and converter registers are zero and the mode register is 2'b11, so `termSel` is 2'b11, `bufEnable` is 0 and `readWord` is 16'h3000.
- R2: In a first byte, bits 7..4 are the command and bits 3..0 are data bits 11..8. A second byte carries data bits 7..0.
- R3: Command 4'b1100 loads the 12-bit value into both data registers at the commit that follows the second byte.
- R4: Command 4'b1101 loads only the staging register, and `dacCode` keeps its value.
- R5: Command 4'b1110 moves the old staging value into the converter register and stores the new value in the staging register, both at the same commit.
- R6: Command 4'b1111 copies the staging register into the converter register at the commit of the first byte. Its data nibble and any later data byte in the same transfer have no effect.
- R7: A command whose bits 7..6 are 2'b10 changes no register and raises `readPulse` for exactly one cycle after the commit of its first byte. `readWord` is always {2'b00, mode[1:0], converter[11:0]}.
- R8: A command whose bits 7..6 are 2'b01 loads the mode register from first-byte bits 3..2 at that byte's commit. `termSel` equals the mode: 00 means drive, 01 means float, 10 means low-ohm pull-down and 11 means high-ohm pull-down. `bufEnable` is 1 only for mode 00. A later data byte in the same transfer is ignored.
- R9: Both data registers keep their values through every power-down mode, and waking up with mode 00 drives the retained converter value again.
- R10: An abort discards any command that has not yet committed, so a following commit strobe changes nothing.
- R11: Commands whose bits 7..6 are 2'b00 change no register.
- R12: A new first byte discards any uncommitted earlier byte and starts a new decode.
- R13: Registers change only on the clock edge that samples the commit strobe, and the new values appear on the outputs from the next cycle. A byte strobe on its own changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| byteValid | input | 1 | One-cycle strobe: a received byte is on `byteData` |
| byteIsFirst | input | 1 | Marks the strobed byte as the first byte after the address |
| byteData | input | 8 | Received byte |
| ackCommit | input | 1 | One-cycle strobe at the falling edge of the acknowledge clock |
| abortXfer | input | 1 | One-cycle strobe: the transfer ended before its commit |
| dacCode | output | 12 | Code fed to the converter, taken from the converter register |
| bufEnable | output | 1 | Output buffer enable |
| termSel | output | 2 | Output termination select (the mode register) |
| readWord | output | 16 | Readback word for the slave to transmit |
| readPulse | output | 1 | Pulses for one cycle when a read request is accepted |

## Verification
The internal state that can go wrong here is the decode position (which byte the next commit belongs to) and the staging register, which has no output of its own. A stale decode position shows up on `dacCode` or `termSel` at the very next commit strobe, as a write that should not happen or a write that is missing. A wrong staging value stays hidden until a promote command copies it out. For that reason the directed scenarios follow every staging-only write with a promote and check `dacCode` one cycle after that commit.

// File: rtl/dac_cmd_pkg.sv
package dac_cmd_pkg;
  localparam int BYTE_W = 8;
  localparam int DATA_W = 12;
  localparam int PD_W   = 2;
  localparam int HI_W   = DATA_W - BYTE_W;
  localparam int CMD_W  = BYTE_W - HI_W;
  localparam int WORD_W = 2 * BYTE_W;
  localparam int PAD_W  = WORD_W - PD_W - DATA_W;
  localparam logic [PD_W-1:0] PD_DRIVE = '0;
  localparam logic [PD_W-1:0] PD_RESET = '1;

  typedef enum logic [2:0] {
    K_NONE, K_POWER, K_READ, K_PROMOTE, K_LOAD_BOTH, K_LOAD_IN, K_LOAD_SWAP
  } cmd_kind_e;

  typedef enum logic [2:0] {
    S_IDLE, S_HAVE_CMD, S_WAIT_LO, S_HAVE_LO, S_DONE
  } xfer_state_e;

  typedef struct packed {
    logic wrInput;
    logic wrDacNew;
    logic wrDacOld;
    logic wrPower;
    logic readReq;
  } cmd_strobe_t;

  function automatic cmd_kind_e decodeCmd(input logic [CMD_W-1:0] c);
    unique case (c[CMD_W-1 -: 2])
      2'b01:   return K_POWER;
      2'b10:   return K_READ;
      2'b11: begin
        unique case (c[1:0])
          2'b00:   return K_LOAD_BOTH;
          2'b01:   return K_LOAD_IN;
          2'b10:   return K_LOAD_SWAP;
          default: return K_PROMOTE;
        endcase
      end
      default: return K_NONE;
    endcase
  endfunction
endpackage

// File: rtl/dac_cmd_ctrl.sv
module dac_cmd_ctrl
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic              byteIsFirst,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              ackCommit,
  input  logic              abortXfer,
  output cmd_strobe_t       strb,
  output logic [DATA_W-1:0] newData
);
  xfer_state_e state, stateNext;
  logic [CMD_W-1:0]  cmdReg;
  logic [HI_W-1:0]   hiReg;
  logic [BYTE_W-1:0] loReg;
  cmd_kind_e         kind;

  assign kind    = decodeCmd(cmdReg);
  assign newData = {hiReg, loReg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      cmdReg <= '0;
      hiReg  <= '0;
      loReg  <= '0;
    end else begin
      state <= stateNext;
      if (!abortXfer && byteValid) begin
        if (byteIsFirst) begin
          {cmdReg, hiReg} <= byteData;
          loReg           <= '0;
        end else if (state == S_WAIT_LO) begin
          loReg <= byteData;
        end
      end
    end
  end

  always_comb begin
    stateNext = state;
    strb      = '0;
    if (abortXfer) begin
      stateNext = S_IDLE;
    end else if (byteValid) begin
      if (byteIsFirst)             stateNext = S_HAVE_CMD;
      else if (state == S_WAIT_LO) stateNext = S_HAVE_LO;
    end else if (ackCommit) begin
      unique case (state)
        S_HAVE_CMD: begin
          stateNext = S_DONE;
          unique case (kind)
            K_POWER:   strb.wrPower  = 1'b1;
            K_READ:    strb.readReq  = 1'b1;
            K_PROMOTE: strb.wrDacOld = 1'b1;
            K_NONE:    ;
            default:   stateNext = S_WAIT_LO;
          endcase
        end
        S_HAVE_LO: begin
          stateNext = S_DONE;
          unique case (kind)
            K_LOAD_BOTH: begin strb.wrInput = 1'b1; strb.wrDacNew = 1'b1; end
            K_LOAD_IN:   strb.wrInput = 1'b1;
            K_LOAD_SWAP: begin strb.wrInput = 1'b1; strb.wrDacOld = 1'b1; end
            default:     ;
          endcase
        end
        default: ;
      endcase
    end
  end

  // R3: at most one source ever drives the converter register, and never with a mode or read action
  p_single_action_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({strb.wrDacNew, strb.wrDacOld, strb.wrPower, strb.readReq}));

  // R13: no register action without a commit strobe
  p_commit_only_r13: assert property (@(posedge clk) disable iff (!rst_n)
    !ackCommit |-> (strb == '0));
endmodule

// File: rtl/dac_cmd_regs.sv
module dac_cmd_regs
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  cmd_strobe_t       strb,
  input  logic [DATA_W-1:0] newData,
  output logic [DATA_W-1:0] dacCode,
  output logic              bufEnable,
  output logic [PD_W-1:0]   termSel,
  output logic [WORD_W-1:0] readWord,
  output logic              readPulse
);
  logic [DATA_W-1:0] inReg;
  logic [DATA_W-1:0] dacReg;
  logic [PD_W-1:0]   pdReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      inReg     <= '0;
      dacReg    <= '0;
      pdReg     <= PD_RESET;
      readPulse <= 1'b0;
    end else begin
      readPulse <= strb.readReq;
      if (strb.wrDacNew)      dacReg <= newData;
      else if (strb.wrDacOld) dacReg <= inReg;
      if (strb.wrInput)       inReg  <= newData;
      if (strb.wrPower)       pdReg  <= newData[DATA_W-1 -: PD_W];
    end
  end

  assign dacCode   = dacReg;
  assign termSel   = pdReg;
  assign bufEnable = (pdReg == PD_DRIVE);
  assign readWord  = {{PAD_W{1'b0}}, pdReg, dacReg};

  // R5: promotion takes the staging value from before the same-cycle load
  p_promote_old_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrDacOld |=> (dacReg == $past(inReg)));

  // R4: a staging-only load leaves the converter register alone
  p_input_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (strb.wrInput && !strb.wrDacNew && !strb.wrDacOld) |=> $stable(dacReg));

  // R9: mode changes keep both data registers
  p_mode_keeps_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
    strb.wrPower |=> ($stable(dacReg) && $stable(inReg)));
endmodule

// File: rtl/dac_cmd_bank.sv
module dac_cmd_bank
  import dac_cmd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byteValid,
  input  logic              byteIsFirst,
  input  logic [BYTE_W-1:0] byteData,
  input  logic              ackCommit,
  input  logic              abortXfer,
  output logic [DATA_W-1:0] dacCode,
  output logic              bufEnable,
  output logic [PD_W-1:0]   termSel,
  output logic [WORD_W-1:0] readWord,
  output logic              readPulse
);
  cmd_strobe_t       strb;
  logic [DATA_W-1:0] newData;

  dac_cmd_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteIsFirst(byteIsFirst),
    .byteData(byteData), .ackCommit(ackCommit), .abortXfer(abortXfer),
    .strb(strb), .newData(newData)
  );

  dac_cmd_regs u_regs (
    .clk(clk), .rst_n(rst_n), .strb(strb), .newData(newData),
    .dacCode(dacCode), .bufEnable(bufEnable), .termSel(termSel),
    .readWord(readWord), .readPulse(readPulse)
  );

  // R10: an abort cycle never changes the outputs
  p_abort_no_change_r10: assert property (@(posedge clk) disable iff (!rst_n)
    abortXfer |=> ($stable(dacCode) && $stable(termSel)));
endmodule

// File: tb/dac_cmd_bank_bench.sv
module dac_cmd_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        byteValid = 1'b0;
  logic        byteIsFirst = 1'b0;
  logic [7:0]  byteData = '0;
  logic        ackCommit = 1'b0;
  logic        abortXfer = 1'b0;
  logic [11:0] dacCode;
  logic        bufEnable;
  logic [1:0]  termSel;
  logic [15:0] readWord;
  logic        readPulse;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  dac_cmd_bank u_dac_cmd_bank (
    .clk(clk), .rst_n(rst_n), .byteValid(byteValid), .byteIsFirst(byteIsFirst),
    .byteData(byteData), .ackCommit(ackCommit), .abortXfer(abortXfer),
    .dacCode(dacCode), .bufEnable(bufEnable), .termSel(termSel),
    .readWord(readWord), .readPulse(readPulse)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic first(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIsFirst = 1'b1; byteData = b;
    @(negedge clk); byteValid = 1'b0; byteIsFirst = 1'b0;
  endtask

  task automatic second(input logic [7:0] b);
    @(negedge clk); byteValid = 1'b1; byteIsFirst = 1'b0; byteData = b;
    @(negedge clk); byteValid = 1'b0;
  endtask

  task automatic ack();
    @(negedge clk); ackCommit = 1'b1;
    @(negedge clk); ackCommit = 1'b0;
  endtask

  task automatic abortNow();
    @(negedge clk); abortXfer = 1'b1;
    @(negedge clk); abortXfer = 1'b0;
  endtask

  task automatic t_reset();
    chk("R1 dacCode", {4'h0, dacCode}, 16'h0000);
    chk("R1 termSel", {14'h0, termSel}, 16'h0003);
    chk("R1 bufEnable", {15'h0, bufEnable}, 16'h0000);
    chk("R1 readWord", readWord, 16'h3000);
  endtask

  task automatic t_wake();
    first(8'h40); ack();
    chk("R8 wake termSel", {14'h0, termSel}, 16'h0000);
    chk("R8 wake bufEnable", {15'h0, bufEnable}, 16'h0001);
  endtask

  task automatic t_load_both();
    first(8'hCA); ack();
    chk("R13 after first ack", {4'h0, dacCode}, 16'h0000);
    second(8'hBC);
    chk("R13 byte strobe alone", {4'h0, dacCode}, 16'h0000);
    ack();
    chk("R3 R2 load both", {4'h0, dacCode}, 16'h0ABC);
    chk("R7 readWord", readWord, 16'h0ABC);
  endtask

  task automatic t_input_only();
    first(8'hD1); ack(); second(8'h23); ack();
    chk("R4 dac unchanged", {4'h0, dacCode}, 16'h0ABC);
    first(8'hF5); ack();
    chk("R6 promote staging", {4'h0, dacCode}, 16'h0123);
    second(8'h77); ack();
    chk("R6 extra byte ignored", {4'h0, dacCode}, 16'h0123);
  endtask

  task automatic t_swap();
    first(8'hD7); ack(); second(8'h89); ack();
    first(8'hE4); ack(); second(8'h56); ack();
    chk("R5 old staging to dac", {4'h0, dacCode}, 16'h0789);
    first(8'hF0); ack();
    chk("R5 new staging kept", {4'h0, dacCode}, 16'h0456);
  endtask

  task automatic t_read();
    first(8'h80);
    @(negedge clk); ackCommit = 1'b1;
    @(negedge clk); ackCommit = 1'b0;
    chk("R7 readPulse high", {15'h0, readPulse}, 16'h0001);
    chk("R7 readWord", readWord, 16'h0456);
    @(negedge clk);
    chk("R7 readPulse one cycle", {15'h0, readPulse}, 16'h0000);
    chk("R7 no change", {4'h0, dacCode}, 16'h0456);
  endtask

  task automatic t_power();
    first(8'h44); ack();
    chk("R8 float termSel", {14'h0, termSel}, 16'h0001);
    chk("R8 float bufEnable", {15'h0, bufEnable}, 16'h0000);
    second(8'hFF); ack();
    chk("R8 data byte ignored", {4'h0, dacCode}, 16'h0456);
    chk("R8 mode kept", {14'h0, termSel}, 16'h0001);
    first(8'h48); ack();
    chk("R8 low-ohm termSel", {14'h0, termSel}, 16'h0002);
    first(8'h4C); ack();
    chk("R7 readWord in power-down", readWord, 16'h3456);
    first(8'h40); ack();
    chk("R9 restored dac", {4'h0, dacCode}, 16'h0456);
    chk("R9 buffer on", {15'h0, bufEnable}, 16'h0001);
    first(8'hF0); ack();
    chk("R9 staging retained", {4'h0, dacCode}, 16'h0456);
  endtask

  task automatic t_abort();
    first(8'hC9); ack(); second(8'h99); abortNow(); ack();
    chk("R10 abort after second byte", {4'h0, dacCode}, 16'h0456);
    first(8'hF0); ack();
    chk("R10 staging untouched", {4'h0, dacCode}, 16'h0456);
    first(8'h4C); abortNow(); ack();
    chk("R10 abort before first ack", {14'h0, termSel}, 16'h0000);
  endtask

  task automatic t_ignored();
    first(8'h0F); ack(); second(8'h00); ack();
    chk("R11 dac", {4'h0, dacCode}, 16'h0456);
    chk("R11 mode", {14'h0, termSel}, 16'h0000);
  endtask

  task automatic t_restart();
    first(8'hC1); ack(); second(8'h11);
    first(8'hF0); ack();
    chk("R12 restart discards pending", {4'h0, dacCode}, 16'h0456);
    ack();
    chk("R12 stray ack", {4'h0, dacCode}, 16'h0456);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_wake();
    t_load_both();
    t_input_only();
    t_swap();
    t_read();
    t_power();
    t_abort();
    t_ignored();
    t_restart();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule